// File: doc/BRIEF.md
# Register File Window Address Translator

This block sits between a CPU core and a 1 Kbyte register RAM. It turns the 8-bit direct register address issued by the core into a 10-bit physical address. A window select register, written through a one-cycle write strobe, decides whether the top part of the low 256-byte register space is redirected to another slice of the RAM.

The select value sets the size of the window and where it starts in physical memory. A 128-byte window replaces logical 80H–FFH. A 64-byte window replaces C0H–FFH. A 32-byte window replaces E0H–FFH. Logical addresses below the active window are not redirected and pass through. Physical 0000H–0017H holds the special function registers, and 0018H–03FFH holds register RAM, so every window base lands inside the 1 Kbyte space.

The translation is purely combinational from the registered select value. An access costs no cycle of latency. A select write changes the mapping starting with the next cycle.

Top module: `regwin_xlate`

## Requirements
- R1: After reset the select register holds 00H, and every valid access gives `phy_addr` = zero-extended `acc_addr` with `phy_windowed` = 0.
- R2: With select bits [6:3] = 0010 (pattern x0010bbb), a valid access in 80H–FFH gives `phy_addr` = bbb·80H + (`acc_addr` − 80H) with `phy_windowed` = 1.
- R3: With select bits [6:4] = 010 (pattern x010bbbb), a valid access in C0H–FFH gives `phy_addr` = bbbb·40H + (`acc_addr` − C0H) with `phy_windowed` = 1.
- R4: With select bits [6:5] = 10 (pattern x10bbbbb), a valid access in E0H–FFH gives `phy_addr` = bbbbb·20H + (`acc_addr` − E0H) with `phy_windowed` = 1.
- R5: While a window is active, a valid access below that window's start address passes through zero-extended, with `phy_windowed` = 0.
- R6: Any select value not matching R2–R4 disables windowing, and all accesses pass through unchanged. This covers bits [6:4] = 000, 011 or 11x, and bits [6:3] = 0011, which would place a 128-byte base beyond 3FFH.
- R7: Select bit 7 has no effect on translation.
- R8: A value written with `sel_we` applies from the next cycle on. An access in the same cycle as the write is translated with the previous value.
- R9: `phy_valid` equals `acc_valid` in the same cycle, and `phy_windowed` is 0 whenever `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the window select register |
| sel_din | input | 8 | New window select value |
| acc_valid | input | 1 | Logical access present |
| acc_addr | input | 8 | Logical direct register address |
| phy_valid | output | 1 | Physical address present |
| phy_addr | output | 10 | Physical register RAM address |
| phy_windowed | output | 1 | Access was redirected through a window |

## Verification
A select write and an access can arrive in the same cycle. That is the one place where register timing and address translation meet. The bench provokes it by asserting `sel_we` and `acc_valid` together with an address inside both the old and the new window ranges. It checks that the access follows the old mapping and that the following access follows the new one. The behavioural model in the bench applies the written value only after the comparison for that cycle. Every cycle's outputs are compared against it, with sweeps of all 256 logical addresses for select values of each window size.

// File: rtl/regwin_xlate.sv
module regwin_xlate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_we,
  input  logic [7:0] sel_din,
  input  logic       acc_valid,
  input  logic [7:0] acc_addr,
  output logic       phy_valid,
  output logic [9:0] phy_addr,
  output logic       phy_windowed
);

  logic [6:0] sel_q;
  logic       unused_sel_msb;

  assign unused_sel_msb = sel_din[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_din[6:0];

  logic mode128, mode64, mode32;
  logic hit128, hit64, hit32;

  assign mode128 = (sel_q[6:3] == 4'b0010);
  assign mode64  = (sel_q[6:4] == 3'b010);
  assign mode32  = (sel_q[6:5] == 2'b10);

  assign hit128 = mode128 & acc_addr[7];
  assign hit64  = mode64  & (&acc_addr[7:6]);
  assign hit32  = mode32  & (&acc_addr[7:5]);

  always_comb begin
    phy_addr = {2'b00, acc_addr};
    if (hit128)     phy_addr = {sel_q[2:0], acc_addr[6:0]};
    else if (hit64) phy_addr = {sel_q[3:0], acc_addr[5:0]};
    else if (hit32) phy_addr = {sel_q[4:0], acc_addr[4:0]};
  end

  assign phy_valid    = acc_valid;
  assign phy_windowed = acc_valid & (hit128 | hit64 | hit32);

endmodule

module regwin_xlate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_we,
  input logic       acc_valid,
  input logic [7:0] acc_addr,
  input logic       phy_valid,
  input logic [9:0] phy_addr,
  input logic       phy_windowed
);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    phy_valid == acc_valid);

  a_r9_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !phy_windowed);

  a_r5_passthru_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !phy_windowed) |-> (phy_addr == {2'b00, acc_addr}));

  a_r5_low_half_never_windowed: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_addr[7]) |-> !phy_windowed);

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    phy_windowed |-> (phy_addr[4:0] == acc_addr[4:0] && acc_addr[7:5] == 3'b111 || acc_addr[7]));

  a_r8_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && acc_valid && $past(acc_valid) && !$past(sel_we) && $stable(acc_addr))
      |-> ($stable(phy_addr) && $stable(phy_windowed)));

endmodule

bind regwin_xlate regwin_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .phy_valid(phy_valid), .phy_addr(phy_addr),
  .phy_windowed(phy_windowed)
);

// File: tb/test_regwin_xlate.sv
`timescale 1ns/1ps
module test_regwin_xlate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_we = 1'b0;
  logic [7:0] sel_din = '0;
  logic       acc_valid = 1'b0;
  logic [7:0] acc_addr = '0;
  logic       phy_valid;
  logic [9:0] phy_addr;
  logic       phy_windowed;

  int total = 0;
  int bad = 0;
  int model_sel = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  regwin_xlate i_regwin_xlate (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_din(sel_din),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .phy_valid(phy_valid),
    .phy_addr(phy_addr), .phy_windowed(phy_windowed)
  );

  function automatic void expect_of(input int s, input int a, output int pa, output int win);
    int top, size, base;
    top = (s / 16) % 8;
    size = 0; base = 0;
    if (top == 1 && (s % 16) < 8) begin size = 128; base = (s % 8) * 128; end
    else if (top == 2)            begin size = 64;  base = (s % 16) * 64; end
    else if (top == 4 || top == 5) begin size = 32; base = (s % 32) * 32; end
    if (size != 0 && a >= 256 - size) begin pa = base + a - (256 - size); win = 1; end
    else begin pa = a; win = 0; end
  endfunction

  task automatic cyc(input bit wr, input int wd, input bit v, input int a);
    int epa, ewin;
    @(negedge clk);
    sel_we = wr; sel_din = 8'(wd); acc_valid = v; acc_addr = 8'(a);
    #1;
    expect_of(model_sel, a, epa, ewin);
    total++;
    if (phy_valid !== v) begin
      bad++;
      $display("FAIL %s valid: actual=%0b expected=%0b", tag, phy_valid, v);
    end
    total++;
    if (phy_windowed !== (v ? ewin[0] : 1'b0)) begin
      bad++;
      $display("FAIL %s windowed sel=%02h addr=%02h: actual=%0b expected=%0b",
               tag, model_sel, a, phy_windowed, v ? ewin[0] : 1'b0);
    end
    if (v) begin
      total++;
      if (phy_addr !== 10'(epa)) begin
        bad++;
        $display("FAIL %s addr sel=%02h addr=%02h: actual=%03h expected=%03h",
                 tag, model_sel, a, phy_addr, epa);
      end
    end
    @(posedge clk);
    if (wr && rst_n) model_sel = wd % 128;
  endtask

  task automatic sweep(input int s, input string t);
    tag = t;
    cyc(1'b1, s, 1'b0, 0);
    for (int a = 0; a < 256; a++) cyc(1'b0, 0, 1'b1, a);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a += 17) cyc(1'b0, 0, 1'b1, a);
    cyc(1'b0, 0, 1'b1, 255);

    sweep(8'h13, "R2");
    sweep(8'h17, "R2");
    sweep(8'h10, "R2");
    sweep(8'h2F, "R3");
    sweep(8'h20, "R3");
    sweep(8'h29, "R3");
    sweep(8'h40, "R4");
    sweep(8'h5F, "R4");
    sweep(8'h4A, "R4");

    sweep(8'h15, "R5");
    sweep(8'h25, "R5");

    sweep(8'h18, "R6");
    sweep(8'h35, "R6");
    sweep(8'h6A, "R6");
    sweep(8'h07, "R6");

    sweep(8'h93, "R7");
    sweep(8'hDF, "R7");
    sweep(8'hAC, "R7");

    tag = "R8";
    cyc(1'b1, 8'h13, 1'b0, 0);
    cyc(1'b1, 8'h2F, 1'b1, 8'hFF);
    cyc(1'b0, 0, 1'b1, 8'hFF);
    cyc(1'b1, 8'h00, 1'b1, 8'hE5);
    cyc(1'b0, 0, 1'b1, 8'hE5);

    tag = "R9";
    cyc(1'b1, 8'h13, 1'b0, 8'hFF);
    cyc(1'b0, 0, 1'b0, 8'hFF);
    cyc(1'b0, 0, 1'b1, 8'hFF);
    cyc(1'b0, 0, 1'b0, 8'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule